// File: doc/BRIEF.md
# APB3 Slot Interconnect with Indirect Upper Address

This block fans one upstream APB3 requester out to a row of downstream APB3 completers. The upstream address is cut into an in-slot offset (the low 16 bits) and a slot index (the bits just above it). Each downstream port owns one slot. The transfer is passed through to that port, and the port's read data, ready and error come back to the requester.

Slot 1 has no downstream completer. It holds a local register that stores the top half of a 32-bit address. Any transfer aimed at slot 0 leaves the block with an address made of that stored top half followed by the incoming 16-bit offset. A narrow upstream bus can therefore reach a full 32-bit space through slot 0. Every other slot gets its offset with zeros above it. A slot index that has no attached port is answered inside the block with an error.

The number of slots and the width of the offset and the index are parameters.

Top module: `apb_slot_fabric`

## Requirements
- R1: The slot index is `up_addr[19:16]` and the offset is `up_addr[15:0]`. While `up_sel` is high, only the `dn_sel` bit of the decoded slot may be high. While `up_sel` is low, all of `dn_sel` is low. `dn_en`, `dn_write` and `dn_wdata` follow the upstream enable, direction and write data.
- R2: `dn_sel[1]` is never asserted. The register at slot 1 has these properties:
  - A write stores `up_wdata[31:16]` and ignores `up_wdata[15:0]`.
  - A read returns the stored value in bits 31:16 and zero in bits 15:0.
  - Every access to it completes in one access cycle with `up_err` low.
- R3: During a slot 0 transfer, `dn_addr` is the stored upper half in bits 31:16, followed by the upstream offset in bits 15:0. For example, storing 0x40010000 and then accessing offset 0x3088 gives 0x40013088.
- R4: During a transfer to any other attached slot, `dn_addr` is the offset with bits 31:16 at zero.
- R5: During a transfer to an attached slot, the following come only from that slot's port, so wait states stretch the access:
  - `up_rdata` comes from that slot's 32-bit field of `dn_rdata`, which is bits k*32+31:k*32 for slot k.
  - `up_ready` comes from `dn_ready`.
  - `up_err` comes from `dn_err`.
- R6: A slot index of NUM_SLOTS or above has no port. No `dn_sel` bit rises, and the access completes in its first access cycle with `up_ready` high, `up_err` high and `up_rdata` zero.
- R7: The active-low reset clears the stored upper half to zero.
- R8: A register write takes effect for the very next slot 0 transfer, including one that starts in the cycle right after the write.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| up_sel | input | 1 | Upstream select |
| up_en | input | 1 | Upstream enable (access phase) |
| up_write | input | 1 | Upstream direction, high for write |
| up_addr | input | 20 | Upstream address: slot index and offset |
| up_wdata | input | 32 | Upstream write data |
| up_rdata | output | 32 | Read data returned upstream |
| up_ready | output | 1 | Ready returned upstream |
| up_err | output | 1 | Error returned upstream |
| dn_sel | output | NUM_SLOTS | Per-slot downstream select |
| dn_en | output | 1 | Shared downstream enable |
| dn_write | output | 1 | Shared downstream direction |
| dn_addr | output | 32 | Shared downstream address |
| dn_wdata | output | 32 | Shared downstream write data |
| dn_rdata | input | 32*NUM_SLOTS | Read data, slot k in bits k*32+31:k*32 |
| dn_ready | input | NUM_SLOTS | Per-slot ready |
| dn_err | input | NUM_SLOTS | Per-slot error, tied low where a completer has none |

## Verification
The bench stores a value with non-zero low bits, reads it back, and checks that only the top half survived. A design that kept the whole word would return those low bits. A slot 0 access placed in the very cycle after a register write would expose a design that used a stale or extra-registered upper half. Wait states and errors are driven on one port while a different slot is addressed, which catches a response mux that ORs or mixes ports. Unattached indices and a second reset catch a design that hangs on an empty slot, selects a port for it, or keeps the stored address across reset.

// File: rtl/apb_slot_pkg.sv
package apb_slot_pkg;
  localparam int DW = 32;
  localparam int AW = 32;

  typedef struct packed {
    logic [DW-1:0] rdata;
    logic          ready;
    logic          err;
  } slot_resp_t;
endpackage

// File: rtl/apb_slot_decode.sv
module apb_slot_decode #(
  parameter int NUM_SLOTS = 4,
  parameter int OFS_W     = 16,
  parameter int IDX_W     = 4,
  parameter int REG_SLOT  = 1
) (
  input  logic                   sel,
  input  logic [OFS_W+IDX_W-1:0] addr,
  output logic [NUM_SLOTS-1:0]   port_hit,
  output logic                   reg_hit,
  output logic                   empty_hit
);
  logic [IDX_W-1:0] idx;
  assign idx = addr[OFS_W+IDX_W-1:OFS_W];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
    if (i == REG_SLOT) begin : g_reg
      assign port_hit[i] = 1'b0;
    end else begin : g_port
      assign port_hit[i] = sel && (idx == IDX_W'(i));
    end
  end

  assign reg_hit   = sel && (idx == IDX_W'(REG_SLOT));
  assign empty_hit = sel && !reg_hit && !(|port_hit);
endmodule

// File: rtl/apb_ind_reg.sv
module apb_ind_reg #(
  parameter int HI_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [HI_W-1:0] wr_hi,
  output logic [HI_W-1:0] hi_q
);
  logic [HI_W-1:0] hi_d;

  always_comb begin
    hi_d = hi_q;
    if (wr_en) hi_d = wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_d;
  end
endmodule

// File: rtl/apb_resp_mux.sv
module apb_resp_mux
  import apb_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0]    port_hit,
  input  logic                    reg_hit,
  input  logic                    empty_hit,
  input  logic [DW-1:0]           reg_rdata,
  input  logic [NUM_SLOTS*DW-1:0] dn_rdata,
  input  logic [NUM_SLOTS-1:0]    dn_ready,
  input  logic [NUM_SLOTS-1:0]    dn_err,
  output slot_resp_t              resp
);
  always_comb begin
    resp = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (port_hit[i]) begin
        resp.rdata = resp.rdata | dn_rdata[i*DW +: DW];
        resp.ready = resp.ready | dn_ready[i];
        resp.err   = resp.err   | dn_err[i];
      end
    end
    if (reg_hit) begin
      resp.rdata = reg_rdata;
      resp.ready = 1'b1;
    end
    if (empty_hit) begin
      resp.ready = 1'b1;
      resp.err   = 1'b1;
    end
  end
endmodule

// File: rtl/apb_slot_fabric.sv
module apb_slot_fabric
  import apb_slot_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int OFS_W     = 16,
  parameter int IDX_W     = 4
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        up_sel,
  input  logic                        up_en,
  input  logic                        up_write,
  input  logic [OFS_W+IDX_W-1:0]      up_addr,
  input  logic [DW-1:0]               up_wdata,
  output logic [DW-1:0]               up_rdata,
  output logic                        up_ready,
  output logic                        up_err,
  output logic [NUM_SLOTS-1:0]        dn_sel,
  output logic                        dn_en,
  output logic                        dn_write,
  output logic [AW-1:0]               dn_addr,
  output logic [DW-1:0]               dn_wdata,
  input  logic [NUM_SLOTS*DW-1:0]     dn_rdata,
  input  logic [NUM_SLOTS-1:0]        dn_ready,
  input  logic [NUM_SLOTS-1:0]        dn_err
);
  localparam int HI_W     = AW - OFS_W;
  localparam int REG_SLOT = 1;
  localparam int WIDE_SLOT = 0;

  logic [NUM_SLOTS-1:0] port_hit;
  logic                 reg_hit;
  logic                 empty_hit;
  logic                 reg_wr;
  logic [HI_W-1:0]      hi_q;
  logic [OFS_W-1:0]     offset;
  slot_resp_t           resp;

  apb_slot_decode #(
    .NUM_SLOTS(NUM_SLOTS), .OFS_W(OFS_W), .IDX_W(IDX_W), .REG_SLOT(REG_SLOT)
  ) u_decode (
    .sel(up_sel), .addr(up_addr),
    .port_hit(port_hit), .reg_hit(reg_hit), .empty_hit(empty_hit)
  );

  // register commits on the completing access cycle (no wait states)
  assign reg_wr = reg_hit && up_en && up_write;

  apb_ind_reg #(.HI_W(HI_W)) u_ind (
    .clk(pclk), .rst_n(presetn), .wr_en(reg_wr),
    .wr_hi(up_wdata[DW-1:OFS_W]), .hi_q(hi_q)
  );

  apb_resp_mux #(.NUM_SLOTS(NUM_SLOTS)) u_mux (
    .port_hit(port_hit), .reg_hit(reg_hit), .empty_hit(empty_hit),
    .reg_rdata({hi_q, {OFS_W{1'b0}}}),
    .dn_rdata(dn_rdata), .dn_ready(dn_ready), .dn_err(dn_err),
    .resp(resp)
  );

  assign offset   = up_addr[OFS_W-1:0];
  assign dn_sel   = port_hit;
  assign dn_en    = up_en;
  assign dn_write = up_write;
  assign dn_wdata = up_wdata;
  assign dn_addr  = port_hit[WIDE_SLOT] ? {hi_q, offset} : {{HI_W{1'b0}}, offset};

  assign up_rdata = resp.rdata;
  assign up_ready = resp.ready;
  assign up_err   = resp.err;
endmodule

// File: rtl/apb_slot_fabric_chk.sv
module apb_slot_fabric_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int OFS_W     = 16,
  parameter int IDX_W     = 4
) (
  input logic                    pclk,
  input logic                    presetn,
  input logic                    up_sel,
  input logic                    up_en,
  input logic                    up_write,
  input logic [OFS_W+IDX_W-1:0]  up_addr,
  input logic [31:0]             up_wdata,
  input logic [31:0]             up_rdata,
  input logic                    up_ready,
  input logic                    up_err,
  input logic [NUM_SLOTS-1:0]    dn_sel,
  input logic                    dn_en,
  input logic                    dn_write,
  input logic [31:0]             dn_addr,
  input logic [31:0]             dn_wdata,
  input logic [NUM_SLOTS*32-1:0] dn_rdata,
  input logic [NUM_SLOTS-1:0]    dn_ready,
  input logic [NUM_SLOTS-1:0]    dn_err
);
  logic [IDX_W-1:0] idx;
  logic             empty;
  assign idx   = up_addr[OFS_W+IDX_W-1:OFS_W];
  assign empty = ({1'b0, idx} >= (IDX_W+1)'(NUM_SLOTS));

  AST_ONE_SELECT: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(dn_sel) && (up_sel || dn_sel == '0)); // R1
  AST_REG_SLOT_UNSELECTED: assert property (@(posedge pclk) disable iff (!presetn)
    !dn_sel[1]); // R2
  AST_REG_NO_WAIT: assert property (@(posedge pclk) disable iff (!presetn)
    (up_sel && up_en && idx == IDX_W'(1)) |-> (up_ready && !up_err)); // R2
  AST_WIDE_OFFSET: assert property (@(posedge pclk) disable iff (!presetn)
    dn_sel[0] |-> (dn_addr[OFS_W-1:0] == up_addr[OFS_W-1:0])); // R3
  AST_NARROW_UPPER_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (up_sel && idx != IDX_W'(0)) |-> (dn_addr[31:OFS_W] == '0)); // R4
  AST_READY_FROM_SLOT0: assert property (@(posedge pclk) disable iff (!presetn)
    (up_sel && up_en && idx == IDX_W'(0)) |-> (up_ready == dn_ready[0] && up_err == dn_err[0])); // R5
  AST_EMPTY_SLOT_ERR: assert property (@(posedge pclk) disable iff (!presetn)
    (up_sel && up_en && empty) |-> (up_ready && up_err && up_rdata == '0 && dn_sel == '0)); // R6
endmodule

bind apb_slot_fabric apb_slot_fabric_chk #(
  .NUM_SLOTS(NUM_SLOTS), .OFS_W(OFS_W), .IDX_W(IDX_W)
) chk (.*);

// File: tb/apb_slot_fabric_test.sv
module apb_slot_fabric_test;
  localparam int NS = 4;

  logic           pclk;
  logic           presetn;
  logic           up_sel, up_en, up_write;
  logic [19:0]    up_addr;
  logic [31:0]    up_wdata;
  logic [31:0]    up_rdata;
  logic           up_ready, up_err;
  logic [NS-1:0]  dn_sel;
  logic           dn_en, dn_write;
  logic [31:0]    dn_addr, dn_wdata;
  logic [NS*32-1:0] dn_rdata;
  logic [NS-1:0]  dn_ready, dn_err;

  int n_chk = 0;
  int n_fail = 0;
  int stall_slot = 0;
  int stall_n = 0;

  apb_slot_fabric uut (.*);

  // completer models: read data names the slot and echoes the low address bits
  for (genvar k = 0; k < NS; k++) begin : g_model
    assign dn_rdata[k*32 +: 32] = {4'hA, 4'(k), dn_addr[23:0]};
  end

  initial pclk = 1'b0;
  always #10 pclk = ~pclk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one APB transfer; ends just after the completing edge with bus still driven
  task automatic xfer(input bit wr, input logic [19:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic er,
                      output logic [NS-1:0] sel_seen, output logic [31:0] addr_seen,
                      output int acc_cycles);
    @(negedge pclk);
    up_sel = 1'b1; up_en = 1'b0; up_write = wr; up_addr = a; up_wdata = wd;
    @(negedge pclk);
    up_en = 1'b1;
    acc_cycles = 0;
    forever begin
      dn_ready = '1;
      if (acc_cycles < stall_n) dn_ready[stall_slot] = 1'b0;
      #2;
      acc_cycles++;
      sel_seen = dn_sel; addr_seen = dn_addr;
      rd = up_rdata; er = up_err;
      if (up_ready) break;
      @(negedge pclk);
    end
    @(posedge pclk);
  endtask

  task automatic idle();
    @(negedge pclk);
    up_sel = 1'b0; up_en = 1'b0; dn_ready = '1;
  endtask

  // {wr, addr, wdata, chk_rd, exp_rd, exp_err, exp_sel, exp_dnaddr}
  localparam int VW = 1 + 20 + 32 + 1 + 32 + 1 + 4 + 32;
  localparam logic [VW-1:0] VEC [12] = '{
    {1'b1, 20'h10000, 32'h40010000, 1'b0, 32'h0,        1'b0, 4'b0000, 32'h0},
    {1'b0, 20'h10000, 32'h0,        1'b1, 32'h40010000, 1'b0, 4'b0000, 32'h0},
    {1'b1, 20'h03088, 32'h12345678, 1'b0, 32'h0,        1'b0, 4'b0001, 32'h40013088},
    {1'b0, 20'h00010, 32'h0,        1'b1, 32'hA0010010, 1'b0, 4'b0001, 32'h40010010},
    {1'b1, 20'h1FFFC, 32'h1234FFFF, 1'b0, 32'h0,        1'b0, 4'b0000, 32'h0},
    {1'b0, 20'h10004, 32'h0,        1'b1, 32'h12340000, 1'b0, 4'b0000, 32'h0},
    {1'b0, 20'h0ABCD, 32'h0,        1'b1, 32'hA034ABCD, 1'b0, 4'b0001, 32'h1234ABCD},
    {1'b0, 20'h20044, 32'h0,        1'b1, 32'hA2000044, 1'b0, 4'b0100, 32'h00000044},
    {1'b1, 20'h3FFFC, 32'h55AA55AA, 1'b0, 32'h0,        1'b0, 4'b1000, 32'h0000FFFC},
    {1'b0, 20'h30000, 32'h0,        1'b1, 32'hA3000000, 1'b0, 4'b1000, 32'h00000000},
    {1'b0, 20'h40000, 32'h0,        1'b1, 32'h0,        1'b1, 4'b0000, 32'h0},
    {1'b1, 20'hF1234, 32'hDEADBEEF, 1'b0, 32'h0,        1'b1, 4'b0000, 32'h0}
  };

  initial begin
    fork
      begin
        repeat (150000) @(posedge pclk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none
  end

  initial begin
    logic [31:0] rd, da;
    logic        er;
    logic [NS-1:0] sl;
    int cyc;

    up_sel = 0; up_en = 0; up_write = 0; up_addr = '0; up_wdata = '0;
    dn_ready = '1; dn_err = '0;
    presetn = 1'b0;
    repeat (3) @(posedge pclk);
    @(negedge pclk);
    presetn = 1'b1;

    // reset state
    #2;
    check(dn_sel == '0, "R1 idle selects", 32'(dn_sel), 32'h0);
    check(up_ready == 1'b0, "R1 idle ready", 32'(up_ready), 32'h0);
    xfer(1'b0, 20'h10000, 32'h0, rd, er, sl, da, cyc);
    check(rd == 32'h0, "R7 register after reset", rd, 32'h0);
    idle();

    // vector table, transfers issued back to back
    for (int i = 0; i < 12; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      xfer(v[VW-1], v[VW-2 -: 20], v[VW-22 -: 32], rd, er, sl, da, cyc);
      if (v[VW-54]) check(rd == v[VW-55 -: 32], "R5 R2 R6 table rdata", rd, v[VW-55 -: 32]);
      check(er == v[36], "R6 R5 table err", 32'(er), 32'(v[36]));
      check(sl == v[35:32], "R1 R2 R6 table select", 32'(sl), 32'(v[35:32]));
      if (sl != 0) check(da == v[31:0], "R3 R4 table dn_addr", da, v[31:0]);
    end
    idle();

    // register accesses take one access cycle
    xfer(1'b1, 20'h10000, 32'hBEEF1111, rd, er, sl, da, cyc);
    check(cyc == 1, "R2 register write no wait", 32'(cyc), 32'd1);
    // very next transfer goes to slot 0 with the new upper half
    xfer(1'b0, 20'h00000, 32'h0, rd, er, sl, da, cyc);
    check(da == 32'hBEEF0000, "R8 next transfer address", da, 32'hBEEF0000);
    idle();

    // wait states on slot 2 stretch the access
    stall_slot = 2; stall_n = 3;
    xfer(1'b0, 20'h20100, 32'h0, rd, er, sl, da, cyc);
    check(cyc == 4, "R5 wait states", 32'(cyc), 32'd4);
    check(rd == 32'hA2000100, "R5 rdata after waits", rd, 32'hA2000100);
    // stall on slot 3 must not affect slot 0
    stall_slot = 3; stall_n = 5;
    xfer(1'b0, 20'h00004, 32'h0, rd, er, sl, da, cyc);
    check(cyc == 1, "R5 other slot stall ignored", 32'(cyc), 32'd1);
    stall_n = 0;
    idle();

    // errors come only from the addressed slot
    dn_err = 4'b0100;
    xfer(1'b0, 20'h00008, 32'h0, rd, er, sl, da, cyc);
    check(er == 1'b0, "R5 foreign error ignored", 32'(er), 32'h0);
    xfer(1'b0, 20'h20008, 32'h0, rd, er, sl, da, cyc);
    check(er == 1'b1, "R5 own error returned", 32'(er), 32'h1);
    dn_err = '0;
    idle();

    // empty slot completes at once
    xfer(1'b0, 20'h70000, 32'h0, rd, er, sl, da, cyc);
    check(cyc == 1 && er && rd == 0, "R6 empty slot", rd, 32'h0);
    idle();

    // second reset clears the register
    @(negedge pclk); presetn = 1'b0;
    @(negedge pclk); presetn = 1'b1;
    xfer(1'b0, 20'h00020, 32'h0, rd, er, sl, da, cyc);
    check(da == 32'h00000020, "R7 slot0 address after reset", da, 32'h00000020);
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule